// File: doc/BRIEF.md
# I2C EEPROM Write-Path Slave

This block is an I2C target that models the write side of a small byte-wide serial EEPROM. It watches oversampled SCL and SDA lines, recognises START and STOP, and checks the 7-bit device address. It then takes a word address and a run of data bytes. The data bytes are collected in a page buffer. The lower address bits step through that buffer and wrap inside the page. When the master ends the transfer with a STOP, the buffered bytes are copied into an on-chip array during one timed write cycle. During that cycle the block acknowledges nothing, so a master can poll the device until it answers.

A write-protect input is sampled once per transfer, on the SCL falling edge that closes the word-address acknowledge. If it is high at that moment, the first data byte is refused and nothing is written. SDA is driven only through an open-drain enable. A combinational backdoor port exposes the array contents to the surrounding logic.

Top module: `eewr_wr_slave`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal DEV_ADDR (default 0x50, so 0xA0 on the wire) and its lowest bit (R/W) is 0. Any other address byte, including the read form 0xA1, gets no ACK, and the rest of that transfer is ignored until the next START.
- R2: The device address, the word address and each accepted data byte are acknowledged. sda_oe_o goes high only while SCL is low and stays high for the whole ninth clock.
- R3: A STOP after at least one accepted data byte raises busy_o for exactly TWR_CYCLES clocks.
- R4: While busy_o is high, sda_oe_o stays low and a matching device address is not acknowledged. Once busy_o has fallen, the same address is acknowledged again.
- R5: Data bytes are stored starting at the word address. Only the low log2(PAGE_BYTES) address bits increment, and they wrap to the start of the same page (for example 0x4E, 0x4F, 0x40).
- R6: When more than PAGE_BYTES data bytes are sent, a later byte replaces the earlier byte at the same page slot, and only the last value is committed.
- R7: Only slots that received a byte in the transfer are written. Every other array byte keeps its value.
- R8: The write-protect input is sampled on the SCL falling edge that ends the word-address ACK. If it was high, the first data byte is not acknowledged and the array and busy_o are unchanged. A change of the input after that edge has no effect on the transfer.
- R9: A STOP that follows no accepted data byte, or a repeated START after data bytes, starts no write cycle and leaves the array unchanged.
- R10: After reset every array byte reads 0xFF, and sda_oe_o and busy_o are low.
- R11: bd_data_o always shows the array byte at bd_addr_i, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the bus |
| sda_i | input | 1 | Raw SDA level from the bus |
| wp_i | input | 1 | Write-protect level, active high |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| busy_o | output | 1 | High during the internal write cycle |
| bd_addr_i | input | log2(MEM_BYTES) | Backdoor read address |
| bd_data_o | output | 8 | Backdoor read data |

## Verification
The write path is exercised in several ways:
- A sweep writes every page in full with arithmetically generated bytes, and every array location is compared. This separates correct page addressing from aliasing between pages.
- Partial writes that start near the end of a page, and overlong writes of eighteen bytes, separate in-page wraparound from carry into the next page, and show that a later byte replaces an earlier one.
- Write protect held high before the strobe is set against write protect raised just after it. This shows that the strobe point is respected.
- Polling transfers during the busy window, stray addresses, the read bit, a STOP without data and a repeated START show that only a genuine data-bearing STOP commits.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DEV      = 3'd1,
    ST_DEV_ACK  = 3'd2,
    ST_WADR     = 3'd3,
    ST_WADR_ACK = 3'd4,
    ST_DATA     = 3'd5,
    ST_DATA_ACK = 3'd6,
    ST_SKIP     = 3'd7
  } xfer_state_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/eewr_line_sync.sv
module eewr_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic scl_s,
  output logic sda_s,
  output logic wp_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  // bit order in each stage: {wp, sda, scl}; bus lines idle high
  logic [2:0] stg_q [STAGES];
  logic       scl_d_q;
  logic       sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= 3'b011;
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      stg_q[0] <= {wp_i, sda_i, scl_i};
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
      scl_d_q <= stg_q[STAGES-1][0];
      sda_d_q <= stg_q[STAGES-1][1];
    end
  end

  assign scl_s     = stg_q[STAGES-1][0];
  assign sda_s     = stg_q[STAGES-1][1];
  assign wp_s      = stg_q[STAGES-1][2];
  assign scl_rise  = scl_s & ~scl_d_q;
  assign scl_fall  = ~scl_s & scl_d_q;
  assign start_evt = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_evt  = scl_s & scl_d_q & ~sda_d_q & sda_s;

endmodule

// File: rtl/eewr_page_buf.sv
module eewr_page_buf #(
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned IW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_valid
);

  logic [7:0]            ent_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] ent_vld;

  for (genvar g = 0; g < int'(PAGE_BYTES); g++) begin : g_ent
    logic [7:0] d_q;
    logic       v_q;
    logic       hit;

    assign hit = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else begin
        if (hit) d_q <= wr_data;
        if (clr)      v_q <= 1'b0;
        else if (hit) v_q <= 1'b1;
      end
    end

    assign ent_data[g] = d_q;
    assign ent_vld[g]  = v_q;
  end

  assign rd_data  = ent_data[rd_idx];
  assign rd_valid = ent_vld[rd_idx];

endmodule

// File: rtl/eewr_commit.sv
module eewr_commit #(
  parameter int unsigned MEM_BYTES  = 256,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned TWR_CYCLES = 600,
  localparam int unsigned AW = $clog2(MEM_BYTES),
  localparam int unsigned IW = $clog2(PAGE_BYTES),
  localparam int unsigned PW = AW - IW,
  localparam int unsigned CW = $clog2(TWR_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [PW-1:0] page_i,
  input  logic [7:0]    buf_data,
  input  logic          buf_valid,
  output logic [IW-1:0] buf_idx,
  output logic          busy,
  input  logic [AW-1:0] bd_addr,
  output logic [7:0]    bd_data
);

  logic [7:0]    mem_q [MEM_BYTES];
  logic [CW-1:0] cnt_q,  cnt_n;
  logic          walk_q, walk_n;
  logic [IW-1:0] widx_q, widx_n;
  logic [PW-1:0] page_q, page_n;
  logic          mem_we;
  logic [AW-1:0] mem_wa;

  // timer and page walk: the buffer is copied slot by slot in the first
  // PAGE_BYTES clocks of the write window (TWR_CYCLES >= PAGE_BYTES)
  always_comb begin
    cnt_n  = cnt_q;
    walk_n = walk_q;
    widx_n = widx_q;
    page_n = page_q;
    if (go) begin
      cnt_n  = CW'(TWR_CYCLES);
      walk_n = 1'b1;
      widx_n = '0;
      page_n = page_i;
    end else begin
      if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
      if (walk_q) begin
        widx_n = widx_q + 1'b1;
        if (widx_q == IW'(PAGE_BYTES - 1)) walk_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      walk_q <= 1'b0;
      widx_q <= '0;
      page_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      walk_q <= walk_n;
      widx_q <= widx_n;
      page_q <= page_n;
    end
  end

  assign mem_we = walk_q && buf_valid;
  assign mem_wa = {page_q, widx_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < int'(MEM_BYTES); a++) mem_q[a] <= 8'hFF;
    end else if (mem_we) begin
      mem_q[mem_wa] <= buf_data;
    end
  end

  assign buf_idx = widx_q;
  assign busy    = (cnt_q != '0);
  assign bd_data = mem_q[bd_addr];

endmodule

// File: rtl/eewr_wr_slave.sv
module eewr_wr_slave #(
  parameter int unsigned MEM_BYTES   = 256,
  parameter int unsigned PAGE_BYTES  = 16,
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned TWR_CYCLES  = 600,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW = $clog2(MEM_BYTES),
  localparam int unsigned IW = $clog2(PAGE_BYTES),
  localparam int unsigned PW = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          wp_i,
  output logic          sda_oe_o,
  output logic          busy_o,
  input  logic [AW-1:0] bd_addr_i,
  output logic [7:0]    bd_data_o
);
  import eewr_pkg::*;

  logic scl_s, sda_s, wp_s, scl_rise, scl_fall, start_evt, stop_evt;

  eewr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wp_i(wp_i),
    .scl_s(scl_s), .sda_s(sda_s), .wp_s(wp_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  xfer_state_t     st_q, st_n;
  logic [7:0]      sh_q, sh_n;
  logic [3:0]      bit_q, bit_n;
  logic            oe_q, oe_n;
  logic [PW-1:0]   page_q, page_n;
  logic [IW-1:0]   off_q, off_n;
  logic            wp_q, wp_n;
  logic            got_q, got_n;
  logic            buf_clr, buf_wr, commit_go;
  logic [IW-1:0]   rd_idx;
  logic [7:0]      rd_data;
  logic            rd_vld;
  logic            busy;

  always_comb begin
    st_n      = st_q;
    sh_n      = sh_q;
    bit_n     = bit_q;
    oe_n      = oe_q;
    page_n    = page_q;
    off_n     = off_q;
    wp_n      = wp_q;
    got_n     = got_q;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    commit_go = 1'b0;
    if (start_evt) begin
      st_n  = ST_DEV;
      bit_n = '0;
      oe_n  = 1'b0;
      got_n = 1'b0;
    end else if (stop_evt) begin
      st_n      = ST_IDLE;
      oe_n      = 1'b0;
      commit_go = got_q;
      got_n     = 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_WADR, ST_DATA: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_s};
            bit_n = bit_q + 1'b1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (st_q == ST_DEV) begin
              if (sh_q[7:1] == DEV_ADDR && !sh_q[0] && !busy) begin
                oe_n    = 1'b1;
                st_n    = ST_DEV_ACK;
                buf_clr = 1'b1;
              end else begin
                st_n = ST_SKIP;
              end
            end else if (st_q == ST_WADR) begin
              oe_n   = 1'b1;
              st_n   = ST_WADR_ACK;
              page_n = sh_q[AW-1:IW];
              off_n  = sh_q[IW-1:0];
            end else if (wp_q) begin
              st_n = ST_SKIP;
            end else begin
              buf_wr = 1'b1;
              off_n  = off_q + 1'b1;
              got_n  = 1'b1;
              oe_n   = 1'b1;
              st_n   = ST_DATA_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_WADR_ACK, ST_DATA_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            bit_n = '0;
            if (st_q == ST_DEV_ACK) begin
              st_n = ST_WADR;
            end else begin
              st_n = ST_DATA;
              if (st_q == ST_WADR_ACK) wp_n = wp_s;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      oe_q   <= 1'b0;
      page_q <= '0;
      off_q  <= '0;
      wp_q   <= 1'b0;
      got_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      bit_q  <= bit_n;
      oe_q   <= oe_n;
      page_q <= page_n;
      off_q  <= off_n;
      wp_q   <= wp_n;
      got_q  <= got_n;
    end
  end

  eewr_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_idx(off_q), .wr_data(sh_q), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_valid(rd_vld)
  );

  eewr_commit #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .TWR_CYCLES(TWR_CYCLES)
  ) u_commit (
    .clk(clk), .rst_n(rst_n), .go(commit_go), .page_i(page_q),
    .buf_data(rd_data), .buf_valid(rd_vld), .buf_idx(rd_idx),
    .busy(busy), .bd_addr(bd_addr_i), .bd_data(bd_data_o)
  );

  assign sda_oe_o = oe_q;
  assign busy_o   = busy;

endmodule

// File: rtl/eewr_checks.sv
module eewr_checks #(
  parameter int unsigned TWR_CYCLES = 600
) (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic busy,
  input logic scl_s,
  input logic start_evt,
  input logic stop_evt,
  input logic got_data,
  input logic wp_lat
);

  int unsigned busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= 0;
    else if (busy) busy_run_q <= busy_run_q + 1;
    else           busy_run_q <= 0;
  end

  p_ack_when_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_busy_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  p_busy_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run_q == TWR_CYCLES));

  p_silent_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_protect_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_lat));

  p_start_discards_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !got_data);

endmodule

bind eewr_wr_slave eewr_checks #(.TWR_CYCLES(TWR_CYCLES)) u_checks (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .busy(busy_o),
  .scl_s(scl_s), .start_evt(start_evt), .stop_evt(stop_evt),
  .got_data(got_q), .wp_lat(wp_q)
);

// File: tb/test_eewr_wr_slave.sv
module test_eewr_wr_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int TWR        = 600;
  localparam int NMEM       = 256;

  logic       clk;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic       wp;
  logic       sda_oe;
  logic       busy;
  logic [7:0] bd_addr;
  logic [7:0] bd_data;
  logic       sda_line;

  assign sda_line = sda_m & ~sda_oe;

  eewr_wr_slave #(.TWR_CYCLES(TWR)) i_eewr_wr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp),
    .sda_oe_o(sda_oe), .busy_o(busy), .bd_addr_i(bd_addr), .bd_data_o(bd_data)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] exp_mem [NMEM];
  int run_len = 0;
  int last_run = 0;
  int busy_starts = 0;
  bit busy_d = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (busy && !busy_d) busy_starts++;
    if (busy) run_len++;
    else if (run_len != 0) begin last_run = run_len; run_len = 0; end
    busy_d = busy;
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic i2c_byte(input logic [7:0] b, output bit ack, output bit oe_high_seen);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = !sda_line;
    oe_high_seen = sda_oe;
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic check_mem(string req);
    for (int a = 0; a < NMEM; a++) begin
      bd_addr = 8'(a);
      #1;
      chk(req, int'(bd_data), int'(exp_mem[a]));
    end
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] sweep_val(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  bit ack, oeh;
  int starts0;

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0; bd_addr = '0;
    for (int a = 0; a < NMEM; a++) exp_mem[a] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 sda_oe", int'(sda_oe), 0);
    chk("R10 busy", int'(busy), 0);
    check_mem("R10/R11 erased");

    // sweep: every page written in full, then the whole array compared
    for (int p = 0; p < 16; p++) begin
      i2c_start();
      i2c_byte(8'hA0, ack, oeh);
      if (p == 0) chk("R1 dev ack", int'(ack), 1);
      i2c_byte(8'(p * 16), ack, oeh);
      if (p == 0) chk("R2 waddr ack", int'(ack), 1);
      for (int k = 0; k < 16; k++) begin
        i2c_byte(sweep_val(p * 16 + k), ack, oeh);
        if (p == 3) chk("R2 data ack", int'(ack), 1);
        exp_mem[p * 16 + k] = sweep_val(p * 16 + k);
      end
      i2c_stop();
      wait_idle();
      if (p == 0) chk("R3 busy length", last_run, TWR);
    end
    check_mem("R5 sweep");

    // byte write followed by acknowledge polling
    i2c_start(); i2c_byte(8'hA0, ack, oeh); i2c_byte(8'h23, ack, oeh);
    i2c_byte(8'h3C, ack, oeh); i2c_stop();
    exp_mem[8'h23] = 8'h3C;
    i2c_start(); i2c_byte(8'hA0, ack, oeh);
    chk("R4 nack while busy", int'(ack), 0);
    chk("R4 oe low while busy", int'(oeh), 0);
    chk("R4 busy during poll", int'(busy), 1);
    i2c_stop();
    begin
      int polls = 0;
      do begin
        i2c_start(); i2c_byte(8'hA0, ack, oeh); i2c_stop();
        polls++;
      end while (!ack && polls < 20);
      chk("R4 poll eventually acked", int'(ack), 1);
      chk("R4 idle at ack", int'(busy), 0);
    end
    check_mem("R7 byte write");

    // wrap within a page
    i2c_start(); i2c_byte(8'hA0, ack, oeh); i2c_byte(8'h4E, ack, oeh);
    for (int k = 0; k < 5; k++) begin
      i2c_byte(8'hB0 + 8'(k), ack, oeh);
      exp_mem[8'h40 + ((8'hE + k) & 15)] = 8'hB0 + 8'(k);
    end
    i2c_stop(); wait_idle();
    check_mem("R5 wrap");

    // overrun: eighteen bytes into one page
    i2c_start(); i2c_byte(8'hA0, ack, oeh); i2c_byte(8'h60, ack, oeh);
    for (int k = 0; k < 18; k++) begin
      i2c_byte(8'hC0 + 8'(k), ack, oeh);
      exp_mem[8'h60 + (k & 15)] = 8'hC0 + 8'(k);
    end
    i2c_stop(); wait_idle();
    chk("R6 slot0 last", int'(exp_mem[8'h60]), 8'hD0);
    check_mem("R6 overrun");

    // wrong address and read bit
    starts0 = busy_starts;
    i2c_start(); i2c_byte(8'hA2, ack, oeh);
    chk("R1 other addr nack", int'(ack), 0);
    i2c_byte(8'h10, ack, oeh); i2c_byte(8'h55, ack, oeh);
    chk("R1 ignored byte nack", int'(ack), 0);
    i2c_stop();
    i2c_start(); i2c_byte(8'hA1, ack, oeh);
    chk("R1 read bit nack", int'(ack), 0);
    i2c_stop(); wait_idle();
    chk("R1 no write cycle", busy_starts, starts0);
    check_mem("R1 unchanged");

    // write protect high at the strobe
    wp = 1'b1;
    i2c_start(); i2c_byte(8'hA0, ack, oeh); i2c_byte(8'h80, ack, oeh);
    i2c_byte(8'h77, ack, oeh);
    chk("R8 data nack", int'(ack), 0);
    i2c_stop(); wp = 1'b0; wait_idle();
    chk("R8 no write cycle", busy_starts, starts0);
    check_mem("R8 protected");

    // write protect raised after the strobe
    i2c_start(); i2c_byte(8'hA0, ack, oeh); i2c_byte(8'h85, ack, oeh);
    wp = 1'b1;
    i2c_byte(8'h99, ack, oeh);
    chk("R8 late wp ack", int'(ack), 1);
    i2c_byte(8'h98, ack, oeh);
    i2c_stop(); wp = 1'b0; wait_idle();
    exp_mem[8'h85] = 8'h99; exp_mem[8'h86] = 8'h98;
    check_mem("R8 late wp written");

    // STOP without data, repeated START after data
    starts0 = busy_starts;
    i2c_start(); i2c_byte(8'hA0, ack, oeh); i2c_byte(8'h31, ack, oeh); i2c_stop();
    wait_idle();
    chk("R9 stop without data", busy_starts, starts0);
    i2c_start(); i2c_byte(8'hA0, ack, oeh); i2c_byte(8'h30, ack, oeh);
    i2c_byte(8'h12, ack, oeh);
    i2c_start(); i2c_stop(); wait_idle();
    chk("R9 repeated start", busy_starts, starts0);
    check_mem("R9 unchanged");

    report();
  end
endmodule